// File: doc/BRIEF.md
# Instruction Reuse Buffer

This block is a result cache that does not speculate. It lets an instruction skip execution when the same instruction has already run at the same address with the same source operand values. The buffer is direct-mapped on the instruction address. Each slot keeps a valid flag, an address tag, the instruction word, both source operand values and the result that was produced.

A lookup port runs alongside fetch/decode. It takes the PC, the instruction word, the current operand values and one ready flag for each operand. One cycle later the block returns a registered reuse indication and the cached result. A reuse hit is final: the pipeline commits the returned result without executing the instruction and does no later check. An insert port records each completed execution and always replaces whatever the addressed slot held before. A flush input invalidates the whole buffer in one cycle.

Top module: `instruction_reuse_buffer`

## Requirements
- R1: While `rst` is high, `rs_hit` and `rs_result` are driven to 0 and every slot becomes invalid. After reset, no lookup hits until an insert has been made.
- R2: The slot index is PC bits [6:2] (32 slots). The tag is PC bits [31:7]. PC bits [1:0] are not used. Two PCs that differ only in their tag share one slot.
- R3: A lookup with `lk_valid` high hits only if all of these hold: the slot is valid, the tag matches, the instruction word matches, both operand values match, and both ready flags are high. On the clock edge after the lookup is presented, `rs_hit` goes to 1 and `rs_result` carries the stored result.
- R4: When the lookup does not hit, or `lk_valid` is low, `rs_hit` is 0 and `rs_result` is 0 on that same registered cycle.
- R5: An insert (`ins_valid` high) overwrites its slot with no condition. The tag, instruction word, operands and result are all replaced and the slot becomes valid. The entry that was there before, including one with a different tag, no longer hits.
- R6: When a lookup and an insert to the same slot happen in the same cycle, the lookup sees the slot contents from before the insert. The new contents become visible from the next cycle on.
- R7: `flush` makes every slot invalid at the next edge. If an insert happens in the same cycle as a flush, the insert is dropped. A lookup in the flush cycle still sees the contents from before the flush.
- R8: If either ready flag is low, the lookup misses, even when every stored field matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all slots |
| lk_valid | input | 1 | Lookup request present |
| lk_pc | input | 32 | Lookup instruction address |
| lk_insn | input | 32 | Lookup instruction word |
| lk_src_a | input | 32 | Current first operand value |
| lk_src_b | input | 32 | Current second operand value |
| lk_rdy_a | input | 1 | First operand value is available |
| lk_rdy_b | input | 1 | Second operand value is available |
| ins_valid | input | 1 | Insert a completed execution |
| ins_pc | input | 32 | Insert instruction address |
| ins_insn | input | 32 | Insert instruction word |
| ins_src_a | input | 32 | Insert first operand value |
| ins_src_b | input | 32 | Insert second operand value |
| ins_result | input | 32 | Insert result value |
| rs_hit | output | 1 | Registered reuse hit |
| rs_result | output | 32 | Registered cached result, 0 on a miss |

## Verification
The bench fills all 32 slots. For each slot it then spoils exactly one compare term at a time: tag, instruction word, first operand, second operand, or one of the two ready flags. A design that leaves any term out of the hit equation returns a stale result that would be committed. It checks tag aliasing: a design that keeps the old entry, or merges the two entries, lets an evicted execution still hit. It checks an insert that collides in the same cycle with a lookup of the same slot, and a flush that arrives together with an insert. A design that forwards the new write into the lookup, or lets the insert survive the flush, shows up as a wrong hit one cycle later.

// File: rtl/irb_pkg.sv
package irb_pkg;

    localparam int PC_W    = 32;
    localparam int XLEN    = 32;
    localparam int ENTRIES = 32;
    localparam int OFS_W   = 2;
    localparam int IDX_W   = $clog2(ENTRIES);
    localparam int TAG_W   = PC_W - IDX_W - OFS_W;

    typedef logic [PC_W-1:0]  pc_t;
    typedef logic [XLEN-1:0]  word_t;
    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [TAG_W-1:0] tag_t;

    typedef struct packed {
        tag_t  tag;
        word_t insn;
        word_t src_a;
        word_t src_b;
        word_t result;
    } slot_t;

    typedef struct packed {
        logic  valid;
        pc_t   pc;
        word_t insn;
        word_t src_a;
        word_t src_b;
        logic  rdy_a;
        logic  rdy_b;
    } probe_t;

    typedef struct packed {
        logic  valid;
        pc_t   pc;
        word_t insn;
        word_t src_a;
        word_t src_b;
        word_t result;
    } record_t;

    typedef struct packed {
        logic  hit;
        word_t result;
    } reply_t;

    function automatic idx_t pc_index(input pc_t pc);
        return pc[OFS_W +: IDX_W];
    endfunction

    function automatic tag_t pc_tag(input pc_t pc);
        return pc[PC_W-1 -: TAG_W];
    endfunction

endpackage

// File: rtl/irb_store.sv
module irb_store
    import irb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic               wr_en,
    input  idx_t               wr_idx,
    input  slot_t              wr_slot,
    input  idx_t               rd_idx,
    output slot_t              rd_slot,
    output logic               rd_live,
    output logic [ENTRIES-1:0] live_vec
);

    slot_t              slots [ENTRIES];
    logic [ENTRIES-1:0] live_q;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        logic sel;
        assign sel = wr_en && (wr_idx == idx_t'(i));

        always_ff @(posedge clk) begin
            if (rst || flush) begin
                live_q[i] <= 1'b0;
            end else if (sel) begin
                live_q[i] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel && !flush) begin
                slots[i] <= wr_slot;
            end
        end
    end

    assign rd_slot  = slots[rd_idx];
    assign rd_live  = live_q[rd_idx];
    assign live_vec = live_q;

endmodule

// File: rtl/irb_match.sv
module irb_match
    import irb_pkg::*;
(
    input  probe_t probe,
    input  slot_t  slot,
    input  logic   slot_live,
    output reply_t reply
);

    localparam int N_TERMS = 7;

    logic [N_TERMS-1:0] terms;

    always_comb begin
        terms[0] = probe.valid;
        terms[1] = slot_live;
        terms[2] = (slot.tag == pc_tag(probe.pc));
        terms[3] = (slot.insn == probe.insn);
        terms[4] = (slot.src_a == probe.src_a);
        terms[5] = (slot.src_b == probe.src_b);
        terms[6] = probe.rdy_a && probe.rdy_b;
    end

    always_comb begin
        reply.hit    = &terms;
        reply.result = reply.hit ? slot.result : '0;
    end

endmodule

// File: rtl/irb_reply_reg.sv
module irb_reply_reg
    import irb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  reply_t d,
    output reply_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/instruction_reuse_buffer.sv
module instruction_reuse_buffer
    import irb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        flush,
    input  logic        lk_valid,
    input  logic [31:0] lk_pc,
    input  logic [31:0] lk_insn,
    input  logic [31:0] lk_src_a,
    input  logic [31:0] lk_src_b,
    input  logic        lk_rdy_a,
    input  logic        lk_rdy_b,
    input  logic        ins_valid,
    input  logic [31:0] ins_pc,
    input  logic [31:0] ins_insn,
    input  logic [31:0] ins_src_a,
    input  logic [31:0] ins_src_b,
    input  logic [31:0] ins_result,
    output logic        rs_hit,
    output logic [31:0] rs_result
);

    probe_t             probe;
    record_t            rec;
    slot_t              wr_slot;
    slot_t              rd_slot;
    logic               rd_live;
    logic [ENTRIES-1:0] entry_live;
    reply_t             reply_d;
    reply_t             reply_q;

    always_comb begin
        probe.valid = lk_valid;
        probe.pc    = lk_pc;
        probe.insn  = lk_insn;
        probe.src_a = lk_src_a;
        probe.src_b = lk_src_b;
        probe.rdy_a = lk_rdy_a;
        probe.rdy_b = lk_rdy_b;

        rec.valid  = ins_valid;
        rec.pc     = ins_pc;
        rec.insn   = ins_insn;
        rec.src_a  = ins_src_a;
        rec.src_b  = ins_src_b;
        rec.result = ins_result;

        wr_slot.tag    = pc_tag(rec.pc);
        wr_slot.insn   = rec.insn;
        wr_slot.src_a  = rec.src_a;
        wr_slot.src_b  = rec.src_b;
        wr_slot.result = rec.result;
    end

    irb_store u_store (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .wr_en    (rec.valid),
        .wr_idx   (pc_index(rec.pc)),
        .wr_slot  (wr_slot),
        .rd_idx   (pc_index(probe.pc)),
        .rd_slot  (rd_slot),
        .rd_live  (rd_live),
        .live_vec (entry_live)
    );

    irb_match u_match (
        .probe     (probe),
        .slot      (rd_slot),
        .slot_live (rd_live),
        .reply     (reply_d)
    );

    irb_reply_reg u_reply (
        .clk (clk),
        .rst (rst),
        .d   (reply_d),
        .q   (reply_q)
    );

    assign rs_hit    = reply_q.hit;
    assign rs_result = reply_q.result;

endmodule

// File: rtl/irb_checker.sv
module irb_checker
    import irb_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               flush,
    input logic               lk_valid,
    input logic               lk_rdy_a,
    input logic               lk_rdy_b,
    input logic               ins_valid,
    input logic [31:0]        ins_pc,
    input logic               rs_hit,
    input logic [31:0]        rs_result,
    input logic [ENTRIES-1:0] entry_live
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!rs_hit && rs_result == '0 && entry_live == '0));

    assert_hit_needs_request_R3: assert property (@(posedge clk) disable iff (rst)
        rs_hit |-> $past(lk_valid));

    assert_miss_zero_R4: assert property (@(posedge clk) disable iff (rst)
        !rs_hit |-> (rs_result == '0));

    assert_insert_live_R5: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && !flush) |=> entry_live[$past(pc_index(ins_pc))]);

    assert_flush_clear_R7: assert property (@(posedge clk) disable iff (rst)
        flush |=> (entry_live == '0));

    assert_ready_gate_R8: assert property (@(posedge clk) disable iff (rst)
        rs_hit |-> $past(lk_rdy_a && lk_rdy_b));

endmodule

bind instruction_reuse_buffer irb_checker u_irb_checker (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .lk_valid   (lk_valid),
    .lk_rdy_a   (lk_rdy_a),
    .lk_rdy_b   (lk_rdy_b),
    .ins_valid  (ins_valid),
    .ins_pc     (ins_pc),
    .rs_hit     (rs_hit),
    .rs_result  (rs_result),
    .entry_live (entry_live)
);

// File: tb/tb_instruction_reuse_buffer.sv
module tb_instruction_reuse_buffer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_pc = '0, lk_insn = '0, lk_src_a = '0, lk_src_b = '0;
    logic        lk_rdy_a = 1'b0, lk_rdy_b = 1'b0;
    logic        ins_valid = 1'b0;
    logic [31:0] ins_pc = '0, ins_insn = '0, ins_src_a = '0, ins_src_b = '0, ins_result = '0;
    logic        rs_hit;
    logic [31:0] rs_result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    instruction_reuse_buffer dut (.*);

    localparam logic [31:0] BASE = 32'h0000_4000;

    function automatic logic [31:0] pc_of(input int i);
        return BASE + 32'(i) * 4;
    endfunction
    function automatic logic [31:0] insn_of(input int i);
        return 32'(i) * 32'h0101_0101 + 32'h13;
    endfunction
    function automatic logic [31:0] a_of(input int i);
        return 32'(i) * 3 + 32'h100;
    endfunction
    function automatic logic [31:0] b_of(input int i);
        return ~32'(i);
    endfunction
    function automatic logic [31:0] r_of(input int i);
        return insn_of(i) ^ (a_of(i) + b_of(i));
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input bit exp_hit, input logic [31:0] exp_res, input string req);
        checks++;
        if (rs_hit !== exp_hit || rs_result !== exp_res) begin
            errors++;
            $display("FAIL %s: hit=%0b result=%h expected hit=%0b result=%h",
                     req, rs_hit, rs_result, exp_hit, exp_res);
        end
    endtask

    task automatic set_lk(input logic [31:0] pc, insn, a, b, input logic ra, rb);
        lk_valid = 1'b1; lk_pc = pc; lk_insn = insn;
        lk_src_a = a; lk_src_b = b; lk_rdy_a = ra; lk_rdy_b = rb;
    endtask

    task automatic set_ins(input logic [31:0] pc, insn, a, b, r);
        ins_valid = 1'b1; ins_pc = pc; ins_insn = insn;
        ins_src_a = a; ins_src_b = b; ins_result = r;
    endtask

    task automatic idle();
        lk_valid = 1'b0; ins_valid = 1'b0; flush = 1'b0;
    endtask

    task automatic look(input logic [31:0] pc, insn, a, b, input logic ra, rb,
                        input bit exp_hit, input logic [31:0] exp_res, input string req);
        set_lk(pc, insn, a, b, ra, rb);
        step();
        check(exp_hit, exp_res, req);
        idle();
    endtask

    task automatic insert(input logic [31:0] pc, insn, a, b, r);
        set_ins(pc, insn, a, b, r);
        step();
        idle();
    endtask

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: hit=%0b result=%h expected completion", rs_hit, rs_result);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        set_lk(pc_of(0), 0, 0, 0, 1, 1);
        repeat (3) step();
        check(1'b0, 32'h0, "R1 reset outputs");
        rst = 1'b0;
        step();
        check(1'b0, 32'h0, "R1 lookup during-reset cleared");
        idle();
        look(pc_of(0), 0, 0, 0, 1, 1, 1'b0, 32'h0, "R1 empty after reset");

        for (int i = 0; i < 32; i++) insert(pc_of(i), insn_of(i), a_of(i), b_of(i), r_of(i));

        for (int i = 0; i < 32; i++) begin
            look(pc_of(i), insn_of(i), a_of(i), b_of(i), 1, 1, 1'b1, r_of(i), "R3 full match hit");
            look(pc_of(i) ^ 32'h0001_0000, insn_of(i), a_of(i), b_of(i), 1, 1, 1'b0, 0, "R2 tag mismatch");
            look(pc_of(i) | 32'h3, insn_of(i), a_of(i), b_of(i), 1, 1, 1'b1, r_of(i), "R2 low pc bits unused");
            look(pc_of(i), insn_of(i) ^ 32'h4, a_of(i), b_of(i), 1, 1, 1'b0, 0, "R3 insn mismatch");
            look(pc_of(i), insn_of(i), a_of(i) + 1, b_of(i), 1, 1, 1'b0, 0, "R3 operand a mismatch");
            look(pc_of(i), insn_of(i), a_of(i), b_of(i) ^ 32'h8000_0000, 1, 1, 1'b0, 0, "R3 operand b mismatch");
            look(pc_of(i), insn_of(i), a_of(i), b_of(i), 0, 1, 1'b0, 0, "R8 operand a not ready");
            look(pc_of(i), insn_of(i), a_of(i), b_of(i), 1, 0, 1'b0, 0, "R8 operand b not ready");
        end

        lk_valid = 1'b0; lk_pc = pc_of(5); lk_insn = insn_of(5);
        lk_src_a = a_of(5); lk_src_b = b_of(5); lk_rdy_a = 1; lk_rdy_b = 1;
        step();
        check(1'b0, 32'h0, "R4 no request no hit");

        insert(pc_of(9) + 32'h80, 32'hDEAD_0001, 32'h11, 32'h22, 32'h33);
        look(pc_of(9), insn_of(9), a_of(9), b_of(9), 1, 1, 1'b0, 0, "R5 aliased old entry evicted");
        look(pc_of(9) + 32'h80, 32'hDEAD_0001, 32'h11, 32'h22, 1, 1, 1'b1, 32'h33, "R5 new entry hits");
        insert(pc_of(9) + 32'h80, 32'hDEAD_0001, 32'h11, 32'h22, 32'h44);
        look(pc_of(9) + 32'h80, 32'hDEAD_0001, 32'h11, 32'h22, 1, 1, 1'b1, 32'h44, "R5 same-key overwrite");

        set_lk(pc_of(3), insn_of(3), a_of(3), b_of(3), 1, 1);
        set_ins(pc_of(3), 32'hBEEF_0003, 32'h1, 32'h2, 32'h99);
        step();
        check(1'b1, r_of(3), "R6 lookup sees pre-insert slot");
        idle();
        look(pc_of(3), insn_of(3), a_of(3), b_of(3), 1, 1, 1'b0, 0, "R6 old gone next cycle");
        look(pc_of(3), 32'hBEEF_0003, 32'h1, 32'h2, 1, 1, 1'b1, 32'h99, "R6 new visible next cycle");

        set_lk(pc_of(7), insn_of(7), a_of(7), b_of(7), 1, 1);
        set_ins(pc_of(8), 32'hCAFE_0008, 32'h5, 32'h6, 32'h77);
        flush = 1'b1;
        step();
        check(1'b1, r_of(7), "R7 lookup in flush cycle sees old");
        idle();
        look(pc_of(8), 32'hCAFE_0008, 32'h5, 32'h6, 1, 1, 1'b0, 0, "R7 insert dropped by flush");
        for (int i = 0; i < 32; i++)
            look(pc_of(i), insn_of(i), a_of(i), b_of(i), 1, 1, 1'b0, 0, "R7 all invalid after flush");

        insert(pc_of(12), insn_of(12), a_of(12), b_of(12), r_of(12));
        look(pc_of(12), insn_of(12), a_of(12), b_of(12), 1, 1, 1'b1, r_of(12), "R5 refill after flush");

        rst = 1'b1;
        step();
        rst = 1'b0;
        look(pc_of(12), insn_of(12), a_of(12), b_of(12), 1, 1, 1'b0, 0, "R1 reset invalidates");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule